// File: doc/BRIEF.md
# Exception and Timer Control Unit

This block holds the system-control state that sits beside the integer pipeline of a small 32-bit core. When the pipeline flags a fault, the unit stores a 5-bit reason code and the program counter of the offending instruction. In the following cycle it asks fetch to jump to a single fixed handler entry point. The handler later fetches the saved PC through the register-indexed read port and jumps back to that address. The saved state therefore lives outside the general register file.

The block also contains a free-running cycle counter and a compare register. After software programs the compare value, the unit raises a timer interrupt when the counter reaches it. The interrupt stays raised until software writes the compare register again. Software addresses all registers through one indexed write strobe and one indexed combinational read port.

Top module: `exc_ctrl_unit`

## Requirements
- R1: While reset is asserted, `redirect` and `timer_irq` are 0. Reads of index 13 (status), index 14 (saved PC) and index 11 (compare) return 0, and the counter holds 0.
- R2: When `exc_req` is high at a clock edge, the next read of index 14 returns `exc_pc` and bits 6:2 of index 13 return `exc_code`.
- R3: `redirect` is high for exactly the cycle after each cycle in which `exc_req` was high. `redirect_pc` always reads 0x0000_1100.
- R4: The counter, read at index 9, grows by one on every clock edge. A write to index 9 instead loads `wr_data`, and the count continues upward from that value.
- R5: A write to index 11 loads the compare value and arms the timer. It also forces `timer_irq` low in the next cycle, and this clear wins over a match in the same cycle.
- R6: Once the timer is armed and the counter equals the compare value at a clock edge, `timer_irq` goes high on that edge. It stays high until the next write to index 11, and bit 15 of index 13 mirrors it.
- R7: A write to index 13 loads the code field from `wr_data[6:2]`. A write to index 14 loads the saved PC from `wr_data`.
- R8: Reads of any index other than 9, 11, 13 and 14 return 0. Writes to such indices leave every readable register unchanged.
- R9: When an exception and a write to index 13 or 14 fall on the same edge, the exception values are stored. A same-edge write to index 9 or 11 still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request from the pipeline |
| exc_code | input | 5 | Reason code for the exception |
| exc_pc | input | 32 | PC of the faulting instruction |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 5 | Register index for the read |
| rd_data | output | 32 | Combinational read data |
| redirect | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Handler entry address |
| timer_irq | output | 1 | Timer interrupt request |

## Verification
Two pairs of events can land on the same clock edge. In the first, an exception is raised together with a register write that targets status, saved PC or counter. In the second, a compare write arrives exactly when the counter matches the old compare value. The bench creates each collision on purpose: it preloads the counter so the match falls on a known edge, and it drives `exc_req` together with `wr_en`. A behavioural model applies the priority rules and is checked against the read port, `redirect` and `timer_irq` on every cycle.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
    localparam int IDX_W = 5;
    localparam logic [IDX_W-1:0] IDX_COUNT   = 5'd9;
    localparam logic [IDX_W-1:0] IDX_COMPARE = 5'd11;
    localparam logic [IDX_W-1:0] IDX_STATUS  = 5'd13;
    localparam logic [IDX_W-1:0] IDX_SAVEPC  = 5'd14;
endpackage

// File: rtl/exc_timer.sv
module exc_timer #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_count,
    input  logic              wr_cmp,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] cmp_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] cmp;
        logic              armed;
        logic              irq;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.count = wr_count ? wr_data : st_q.count + 1'b1;
        if (wr_cmp) begin
            st_d.cmp   = wr_data;
            st_d.armed = 1'b1;
            st_d.irq   = 1'b0;
        end else if (st_q.armed && (st_q.count == st_q.cmp)) begin
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign cmp_o   = st_q.cmp;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/exc_state.sv
module exc_state #(
    parameter int DATA_W = 32,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [DATA_W-1:0] exc_pc,
    input  logic              wr_status,
    input  logic              wr_savepc,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CODE_W-1:0] code_o,
    output logic [DATA_W-1:0] savepc_o,
    output logic              redirect_o
);
    localparam int CODE_LSB = 2;
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] savepc;
        logic              redirect;
    } exc_st_t;

    exc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.redirect = exc_req;
        if (exc_req) begin
            st_d.code   = exc_code;
            st_d.savepc = exc_pc;
        end else begin
            if (wr_status) st_d.code   = wr_data[CODE_MSB:CODE_LSB];
            if (wr_savepc) st_d.savepc = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o     = st_q.code;
    assign savepc_o   = st_q.savepc;
    assign redirect_o = st_q.redirect;
endmodule

// File: rtl/exc_readmux.sv
module exc_readmux
    import exc_ctrl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CODE_W  = 5,
    parameter int IRQ_BIT = 15
) (
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] count,
    input  logic [DATA_W-1:0] cmp,
    input  logic [CODE_W-1:0] code,
    input  logic [DATA_W-1:0] savepc,
    input  logic              irq,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CODE_LSB = 2;
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word = '0;
        status_word[CODE_MSB:CODE_LSB] = code;
        status_word[IRQ_BIT] = irq;
    end

    always_comb begin
        unique case (rd_idx)
            IDX_COUNT:   rd_data = count;
            IDX_COMPARE: rd_data = cmp;
            IDX_STATUS:  rd_data = status_word;
            IDX_SAVEPC:  rd_data = savepc;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_ctrl_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          CODE_W  = 5,
    parameter int          IRQ_BIT = 15,
    parameter logic [31:0] VECTOR  = 32'h0000_1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [DATA_W-1:0] exc_pc,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              redirect,
    output logic [DATA_W-1:0] redirect_pc,
    output logic              timer_irq
);
    logic              wr_count, wr_cmp, wr_status, wr_savepc;
    logic [DATA_W-1:0] count_w, cmp_w, savepc_w;
    logic [CODE_W-1:0] code_w;

    assign wr_count  = wr_en && (wr_idx == IDX_COUNT);
    assign wr_cmp    = wr_en && (wr_idx == IDX_COMPARE);
    assign wr_status = wr_en && (wr_idx == IDX_STATUS);
    assign wr_savepc = wr_en && (wr_idx == IDX_SAVEPC);

    exc_timer #(.DATA_W(DATA_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .wr_count(wr_count), .wr_cmp(wr_cmp),
        .wr_data(wr_data), .count_o(count_w), .cmp_o(cmp_w), .irq_o(timer_irq)
    );

    exc_state #(.DATA_W(DATA_W), .CODE_W(CODE_W)) state_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .exc_pc(exc_pc), .wr_status(wr_status), .wr_savepc(wr_savepc),
        .wr_data(wr_data), .code_o(code_w), .savepc_o(savepc_w),
        .redirect_o(redirect)
    );

    exc_readmux #(.DATA_W(DATA_W), .CODE_W(CODE_W), .IRQ_BIT(IRQ_BIT)) rmux_i (
        .rd_idx(rd_idx), .count(count_w), .cmp(cmp_w), .code(code_w),
        .savepc(savepc_w), .irq(timer_irq), .rd_data(rd_data)
    );

    assign redirect_pc = VECTOR[DATA_W-1:0];
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
    parameter int          DATA_W = 32,
    parameter int          CODE_W = 5,
    parameter logic [31:0] VECTOR = 32'h0000_1100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_req,
    input logic [CODE_W-1:0] exc_code,
    input logic [DATA_W-1:0] exc_pc,
    input logic              wr_en,
    input logic [4:0]        wr_idx,
    input logic [4:0]        rd_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic              redirect,
    input logic [DATA_W-1:0] redirect_pc,
    input logic              timer_irq,
    input logic [DATA_W-1:0] count_w,
    input logic [DATA_W-1:0] savepc_w,
    input logic [CODE_W-1:0] code_w
);
    // R3
    redirect_after_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (redirect && redirect_pc == VECTOR[DATA_W-1:0]));
    // R3
    redirect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |=> !redirect);
    // R2
    savepc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (savepc_w == $past(exc_pc) && code_w == $past(exc_code)));
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == 5'd9) |=> (count_w == $past(count_w) + 1'b1));
    // R5
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 5'd11) |=> !timer_irq);
    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_irq && !(wr_en && wr_idx == 5'd11)) |=> timer_irq);
    // R8
    unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx != 5'd9 && rd_idx != 5'd11 && rd_idx != 5'd13 && rd_idx != 5'd14)
        |-> (rd_data == '0));
endmodule

bind exc_ctrl_unit exc_ctrl_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W), .VECTOR(VECTOR)) chk_i (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .exc_pc(exc_pc), .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .rd_data(rd_data), .redirect(redirect), .redirect_pc(redirect_pc),
    .timer_irq(timer_irq), .count_w(count_w), .savepc_w(savepc_w),
    .code_w(code_w)
);

// File: tb/exc_ctrl_unit_tb_top.sv
module exc_ctrl_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        redirect;
    logic [31:0] redirect_pc;
    logic        timer_irq;

    always #2 clk = ~clk;

    exc_ctrl_unit dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .exc_pc(exc_pc), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .redirect(redirect),
        .redirect_pc(redirect_pc), .timer_irq(timer_irq)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [31:0] m_count, m_cmp, m_epc;
    logic [4:0]  m_code;
    logic        m_armed, m_irq, m_redir;

    task automatic model_reset();
        m_count = 0; m_cmp = 0; m_epc = 0; m_code = 0;
        m_armed = 0; m_irq = 0; m_redir = 0;
    endtask

    task automatic model_step();
        logic [31:0] n_count, n_cmp, n_epc;
        logic [4:0]  n_code;
        logic        n_armed, n_irq;
        n_count = (wr_en && wr_idx == 9) ? wr_data : m_count + 1;
        n_cmp = m_cmp; n_armed = m_armed; n_irq = m_irq;
        if (wr_en && wr_idx == 11) begin
            n_cmp = wr_data; n_armed = 1; n_irq = 0;
        end else if (m_armed && m_count == m_cmp) n_irq = 1;
        n_code = m_code; n_epc = m_epc;
        if (exc_req) begin
            n_code = exc_code; n_epc = exc_pc;
        end else begin
            if (wr_en && wr_idx == 13) n_code = wr_data[6:2];
            if (wr_en && wr_idx == 14) n_epc = wr_data;
        end
        m_redir = exc_req;
        m_count = n_count; m_cmp = n_cmp; m_armed = n_armed; m_irq = n_irq;
        m_code = n_code; m_epc = n_epc;
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] idx);
        case (idx)
            5'd9:    return m_count;
            5'd11:   return m_cmp;
            5'd13:   return ({31'b0, m_irq} << 15) | ({27'b0, m_code} << 2);
            5'd14:   return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
        chk(cur_req, rd_data, exp_read(rd_idx));
        chk("R3", {31'b0, redirect}, {31'b0, m_redir});
        chk("R3", redirect_pc, 32'h0000_1100);
        chk("R6", {31'b0, timer_irq}, {31'b0, m_irq});
    endtask

    task automatic idle();
        exc_req = 0; wr_en = 0;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] d);
        wr_en = 1; wr_idx = idx; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic raise(input logic [4:0] code, input logic [31:0] pc);
        exc_req = 1; exc_code = code; exc_pc = pc;
        tick();
        exc_req = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: reset state on several indices
        cur_req = "R1";
        foreach (rd_idx[i]) begin end
        for (int k = 0; k < 4; k++) begin
            rd_idx = (k == 0) ? 5'd13 : (k == 1) ? 5'd14 : (k == 2) ? 5'd11 : 5'd9;
            tick();
        end
        rst_n = 1;
        // R4: free-running counter and load
        cur_req = "R4"; rd_idx = 9;
        for (int k = 0; k < 5; k++) tick();
        wr(9, 32'd100);
        for (int k = 0; k < 3; k++) tick();
        wr(9, 32'hFFFF_FFFE);
        for (int k = 0; k < 4; k++) tick();
        // R6: armed match raises interrupt, status bit mirrors
        cur_req = "R6";
        wr(9, 32'd0);
        rd_idx = 11;
        wr(11, 32'd12);
        rd_idx = 13;
        for (int k = 0; k < 20; k++) tick();
        // R5: compare write clears
        cur_req = "R5";
        wr(11, 32'd1000);
        tick();
        // R5: clear coincides with match
        rd_idx = 13;
        wr(9, 32'd998);
        tick(); tick();
        wr(11, 32'd5);
        for (int k = 0; k < 3; k++) tick();
        // R2: exception capture
        cur_req = "R2";
        rd_idx = 14;
        raise(5'h0C, 32'h0000_0400);
        tick();
        rd_idx = 13;
        raise(5'h1F, 32'hDEAD_BEE0);
        tick();
        // R3: back-to-back exceptions
        cur_req = "R3";
        raise(5'h04, 32'h10);
        raise(5'h08, 32'h14);
        tick();
        // R7: software writes to status and saved PC
        cur_req = "R7";
        rd_idx = 13;
        wr(13, 32'hFFFF_FF7C);
        tick();
        rd_idx = 14;
        wr(14, 32'h1234_5678);
        tick();
        // R8: unimplemented indices
        cur_req = "R8";
        rd_idx = 0; tick();
        rd_idx = 12; tick();
        rd_idx = 31; tick();
        wr(12, 32'hAAAA_5555);
        rd_idx = 12; tick();
        rd_idx = 14; tick();
        rd_idx = 13; tick();
        rd_idx = 11; tick();
        // R9: exception collides with writes
        cur_req = "R9";
        rd_idx = 13;
        exc_req = 1; exc_code = 5'h0D; exc_pc = 32'h800;
        wr_en = 1; wr_idx = 13; wr_data = 32'h0000_0040;
        tick(); idle(); tick();
        rd_idx = 14;
        exc_req = 1; exc_code = 5'h02; exc_pc = 32'h900;
        wr_en = 1; wr_idx = 14; wr_data = 32'hFFFF_0000;
        tick(); idle(); tick();
        rd_idx = 9;
        exc_req = 1; exc_code = 5'h03; exc_pc = 32'hA00;
        wr_en = 1; wr_idx = 9; wr_data = 32'd7777;
        tick(); idle(); tick(); tick();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule